// File: doc/BRIEF.md
# Coded-Ratio System Clock Divider

This block turns one fast reference clock into four synchronous clock-enable streams: processor, fast bus, slow peripheral bus and memory. Each stream is a one-cycle pulse at the reference rate, repeating every N reference cycles. N is chosen per domain by a 4-bit code that indexes a fixed, non-uniform ratio set rather than a binary divide value. Logic in each domain uses the pulse as a clock enable, so the whole subsystem stays on one clock tree.

All four codes, plus three control flags, live in one 32-bit control word written through a simple single-cycle word-write port. Newly written codes are only adopted when the change-permit flag is set. Even then, they are adopted only at a reference cycle where every domain is at the end of its current period, so that all four switch together and no period is ever cut short. The block also provides a half-rate tap, which can be switched to full rate, and a clock-out enable that mirrors the memory pulse when it is turned on.

Top module: `sysdiv_top`

## Requirements
- R1: Code values 0,1,2,3,4,5,6,7,8,9 select divide ratios 1,2,3,4,6,8,12,16,24,32. The processor code is control bits [3:0], the fast-bus code bits [7:4], the slow-bus code bits [11:8] and the memory code bits [15:12]. On dom_tick, bit 0 is processor, 1 fast bus, 2 slow bus and 3 memory.
- R2: Codes 10 to 15 behave exactly as ratio 32.
- R3: A domain with active ratio N pulses for exactly one cycle, then stays low for N-1 cycles. The first edge after reset is released gives a pulse on every domain.
- R4: Reset clears the control word and makes code 0 active on all domains. While code 0 is active, a domain pulses on every cycle. All outputs are low while reset is held.
- R5: With control bit 21 set, tap_tick is high on every cycle. With bit 21 clear, tap_tick is high on alternate cycles, beginning with the first edge after reset.
- R6: With control bit 30 set, ko_tick equals the memory pulse. With bit 30 clear, ko_tick stays low.
- R7: Written codes become active only while control bit 22 is set, and only at a cycle where all four domains are pulsing together. The old ratios finish their periods, and the new ratios count from that shared boundary.
- R8: A write replaces the whole control word in one cycle. It affects the flag-driven outputs from the edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| dom_tick | output | 4 | Per-domain enable pulses (0 processor, 1 fast bus, 2 slow bus, 3 memory) |
| tap_tick | output | 1 | Half-rate or full-rate tap pulse |
| ko_tick | output | 1 | Gated clock-out enable following the memory pulse |

## Verification
The hardest case to reach is a pending change under mixed ratios, for example 3 against 32. There, the shared boundary comes only every 96 cycles, and a change written mid-period must wait for it. The stimulus drives such mixtures, writes new codes at arbitrary phases, and toggles the change-permit flag both on and off while a change is pending. A behavioural model, built on modular phase counters, predicts every pulse on every clock.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;
  localparam int MAX_RATIO = 32;

  // Ratio for a code; any code beyond the table end uses the largest ratio.
  function automatic logic [7:0] code_ratio(input logic [3:0] code);
    case (code)
      4'd0: code_ratio = 8'd1;
      4'd1: code_ratio = 8'd2;
      4'd2: code_ratio = 8'd3;
      4'd3: code_ratio = 8'd4;
      4'd4: code_ratio = 8'd6;
      4'd5: code_ratio = 8'd8;
      4'd6: code_ratio = 8'd12;
      4'd7: code_ratio = 8'd16;
      4'd8: code_ratio = 8'd24;
      default: code_ratio = 8'(MAX_RATIO);
    endcase
  endfunction
endpackage

// File: rtl/sysdiv_dom_counter.sv
module sysdiv_dom_counter #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] load_code,
  output logic              at_zero,
  output logic              tick_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       ratio;
  logic [CNT_W-1:0] reload;

  assign ratio   = sysdiv_pkg::code_ratio(4'(load_code));
  assign reload  = ratio[CNT_W-1:0] - CNT_W'(1);
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= at_zero;
      cnt_q  <= at_zero ? reload : cnt_q - CNT_W'(1);
    end
  end

  logic unused_ratio;
  assign unused_ratio = ^ratio[7:CNT_W];

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_q && reload != '0 && at_zero) |=> !at_zero);
endmodule

// File: rtl/sysdiv_align.sv
module sysdiv_align #(
  parameter int NDOM   = 4,
  parameter int CODE_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NDOM-1:0]        zero_vec,
  input  logic                   chg_en,
  input  logic [NDOM*CODE_W-1:0] req_codes,
  output logic [NDOM*CODE_W-1:0] act_codes,
  output logic [NDOM*CODE_W-1:0] load_codes
);
  logic swap;

  assign swap       = (&zero_vec) && chg_en;
  assign load_codes = swap ? req_codes : act_codes;

  always_ff @(posedge clk) begin
    if (rst) act_codes <= '0;
    else if (swap) act_codes <= req_codes;
  end

  // R7
  align_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(&zero_vec) |=> $stable(act_codes));
endmodule

// File: rtl/sysdiv_half_tap.sv
module sysdiv_half_tap (
  input  logic clk,
  input  logic rst,
  input  logic full_sel,
  output logic tick_q
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      tick_q  <= full_sel | ~phase_q;
    end
  end

  // R5
  tap_full_chk: assert property (@(posedge clk) disable iff (rst)
    $past(full_sel) && !$past(rst) |-> tick_q);
endmodule

// File: rtl/sysdiv_top.sv
module sysdiv_top #(
  parameter int NDOM     = 4,
  parameter int CODE_W   = 4,
  parameter int REG_W    = 32,
  parameter int HALF_BIT = 21,
  parameter int CHG_BIT  = 22,
  parameter int KO_BIT   = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [NDOM-1:0]  dom_tick,
  output logic             tap_tick,
  output logic             ko_tick
);
  localparam int CNT_W   = $clog2(sysdiv_pkg::MAX_RATIO);
  localparam int CODES_W = NDOM * CODE_W;
  localparam int MEM_IDX = NDOM - 1;

  logic [REG_W-1:0]   ctrl_q;
  logic [NDOM-1:0]    zero_vec;
  logic [CODES_W-1:0] act_codes;
  logic [CODES_W-1:0] load_codes;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  sysdiv_align #(.NDOM(NDOM), .CODE_W(CODE_W)) u_align (
    .clk(clk), .rst(rst), .zero_vec(zero_vec), .chg_en(ctrl_q[CHG_BIT]),
    .req_codes(ctrl_q[CODES_W-1:0]), .act_codes(act_codes),
    .load_codes(load_codes)
  );

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    sysdiv_dom_counter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load_code(load_codes[g*CODE_W +: CODE_W]),
      .at_zero(zero_vec[g]), .tick_q(dom_tick[g])
    );

    // R4
    ratio_one_chk: assert property (@(posedge clk) disable iff (rst)
      (act_codes[g*CODE_W +: CODE_W] == '0) |=> dom_tick[g]);
  end

  sysdiv_half_tap u_tap (
    .clk(clk), .rst(rst), .full_sel(ctrl_q[HALF_BIT]), .tick_q(tap_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) ko_tick <= 1'b0;
    else ko_tick <= ctrl_q[KO_BIT] & zero_vec[MEM_IDX];
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_q[REG_W-1:CODES_W]};

  // R6
  ko_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ko_tick |-> dom_tick[MEM_IDX]);
  // R6
  ko_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[KO_BIT] |=> !ko_tick);
endmodule

// File: tb/sysdiv_top_tb.sv
module sysdiv_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  dom_tick;
  logic        tap_tick;
  logic        ko_tick;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string cur_req = "R4";

  always #10 clk = ~clk;

  sysdiv_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .dom_tick(dom_tick), .tap_tick(tap_tick), .ko_tick(ko_tick)
  );

  function automatic int ref_ratio(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 6;
      5: return 8;  6: return 12; 7: return 16; 8: return 24;
      default: return 32;
    endcase
  endfunction

  // Behavioural model: phase positions counting up modulo the ratio.
  int m_ctrl = 0;
  int m_act[4];
  int m_pos[4];
  int m_ph = 0;
  logic [3:0] e_dom = '0;
  logic e_tap = 1'b0, e_ko = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_ph = 0;
      for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_pos[i] = 0; end
      e_dom = '0; e_tap = 1'b0; e_ko = 1'b0;
    end else begin
      bit all0;
      all0 = 1'b1;
      for (int i = 0; i < 4; i++) begin
        e_dom[i] = (m_pos[i] == 0);
        if (m_pos[i] != 0) all0 = 1'b0;
      end
      e_ko  = m_ctrl[30] && (m_pos[3] == 0);
      e_tap = m_ctrl[21] || (m_ph == 0);
      if (all0 && m_ctrl[22])
        for (int i = 0; i < 4; i++) m_act[i] = (m_ctrl >> (4*i)) & 15;
      for (int i = 0; i < 4; i++) m_pos[i] = (m_pos[i] + 1) % ref_ratio(m_act[i]);
      m_ph = 1 - m_ph;
      if (wr_en) m_ctrl = wr_data;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    chk("dom_tick", 32'(dom_tick), 32'(e_dom));
    chk("tap_tick", 32'(tap_tick), 32'(e_tap));
    chk("ko_tick", 32'(ko_tick), 32'(e_ko));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] word(input int c0, c1, c2, c3,
                                       input bit chg, half, ko);
    return 32'(c0 | (c1 << 4) | (c2 << 8) | (c3 << 12)) |
           (32'(chg) << 22) | (32'(half) << 21) | (32'(ko) << 30);
  endfunction

  initial begin
    // R4: reset state and code 0 everywhere
    idle(3); rst = 1'b0; cur_req = "R4"; idle(10);
    // R1: several code mixes
    cur_req = "R1"; wr(word(1, 2, 3, 4, 1, 0, 0)); idle(150);
    wr(word(5, 6, 7, 8, 1, 0, 0)); idle(200);
    cur_req = "R3"; wr(word(9, 0, 1, 2, 1, 0, 0)); idle(200);
    // R2: clamped codes
    cur_req = "R2"; wr(word(10, 12, 15, 9, 1, 0, 0)); idle(200);
    // R7: permit clear, codes must stay
    cur_req = "R7"; wr(word(0, 0, 0, 0, 0, 0, 0)); idle(100);
    // R7: mixed ratios 3 and 32, boundary every 96 cycles
    wr(word(2, 9, 2, 9, 1, 0, 0)); idle(130);
    wr(word(3, 1, 0, 4, 1, 0, 0)); idle(37);
    wr(word(3, 1, 0, 4, 0, 0, 0)); idle(20);
    wr(word(4, 4, 4, 4, 1, 0, 0)); idle(300);
    // R5: tap rate select
    cur_req = "R5"; wr(word(4, 4, 4, 4, 1, 1, 0)); idle(20);
    wr(word(4, 4, 4, 4, 1, 0, 0)); idle(20);
    // R6: clock-out gate
    cur_req = "R6"; wr(word(1, 2, 3, 3, 1, 0, 1)); idle(60);
    wr(word(1, 2, 3, 3, 1, 0, 0)); idle(30);
    // R8: back-to-back writes, last one wins
    cur_req = "R8";
    @(posedge clk); #2; wr_en = 1'b1; wr_data = word(2, 2, 2, 2, 1, 1, 1);
    @(posedge clk); #2; wr_data = word(0, 5, 0, 5, 1, 0, 1);
    @(posedge clk); #2; wr_en = 1'b0;
    idle(100);
    // R4: reset mid-run returns to code 0
    cur_req = "R4"; rst = 1'b1; idle(3); rst = 1'b0; idle(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule